// File: doc/BRIEF.md
# Phase-Adjustable Carrier Clock Divider

This block turns a carrier clock into a slower sample clock. A free-running up-counter on the carrier clock restarts after it reaches a programmable period value. Two compare points set and clear the outputs. The main output, `smp_clk`, rises when the count reaches the lead compare and falls when the count reaches the period. The helper output, `helper_clk`, rises one carrier cycle after each rising edge of `smp_clk` and falls when the count reaches the trailing compare. Its duty cycle is therefore close to one half.

Software or a neighbouring block can shift the phase of both compare points together by a signed number of carrier cycles, modulo the period. A rising edge on `frame_sync` restarts the counter and drops both outputs low, which aligns the divided clock to the start of a received frame. Divider loads and phase steps first go into a shadow set. The counter copies the shadow into the active compare set only when it wraps, so the outputs never produce a short pulse.

Top module: `carrier_phase_div`

## Requirements
- R1: The counter runs from 0 up to the active period value C and then returns to 0, so `smp_clk` repeats every C+1 carrier cycles.
- R2: A divider load sets C to the loaded value, the lead compare to 1 and the trailing compare to 1 + floor(C/2). After reset all three hold the values for a divider of 128 (lead 1, trailing 65).
- R3: `smp_clk` goes high on the edge after a cycle in which the count equals the lead compare, and goes low on the edge after a cycle in which the count equals C. Its high time is C minus the lead compare.
- R4: `helper_clk` goes high on the edge after a cycle in which `smp_clk` has just risen, and goes low on the edge after a cycle in which the count equals the trailing compare. When both events fall in the same cycle, setting wins.
- R5: A phase step with signed value s replaces the lead compare by (lead + s) mod C and the trailing compare by (trail + s) mod C, with remainders in the range 0..C-1, including for |s| > C.
- R6: If a phase step leaves the lead compare at 0, both the lead and the trailing compare are then increased by 1, so the lead compare always stays in 1..C-1.
- R7: A rising edge of `frame_sync` (a cycle in which it is 1 after being 0 in the previous cycle) makes the counter 0 and both outputs low on the next edge, without copying the shadow set.
- R8: Divider loads and phase steps update the shadow set on the next edge. The active set takes the shadow set only on an edge where the counter wraps. A phase step applies to the most recently written shadow values. A divider load in the same cycle as a phase step wins, and the step is dropped.
- R9: A divider value below 2 is loaded as 2.
- R10: During and directly after synchronous reset, both outputs are low and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| div_we | input | 1 | Load `div_val` as the new divider (shadow) |
| div_val | input | 16 | Divider value C |
| step_we | input | 1 | Apply `step_val` as a phase step (shadow) |
| step_val | input | STEP_W | Signed phase step in carrier cycles |
| frame_sync | input | 1 | Frame start; rising edge restarts the divider |
| smp_clk | output | 1 | Divided sample clock (lead output) |
| helper_clk | output | 1 | Helper clock, about 50% duty |

## Verification
A wrong active period value shows up within one period as a wrong distance between `smp_clk` rising edges. A wrong lead or trailing compare shows up in the same period as a high time on `smp_clk` or `helper_clk` that is off by the error. If a configuration is committed at the wrong moment, for example in the middle of a period, one period is cut short; the per-cycle comparison against the bench's model catches this on the first edge where the two differ. A wrap of the phase arithmetic in the wrong direction, or a missing fix for a lead compare of zero, changes the `smp_clk` high time by at least one cycle in the next full period.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int unsigned CDIV_W  = 16;
    localparam int unsigned MIN_DIV = 2;

    typedef logic [CDIV_W-1:0] cval_t;

    typedef struct packed {
        cval_t per;   // period compare (counter wraps after it)
        cval_t lead;  // sets the sample clock
        cval_t trail; // clears the helper clock
    } cmp_set_t;

    function automatic cmp_set_t cmp_from_div(input cval_t d);
        cmp_set_t r;
        cval_t    c;
        c       = (d < cval_t'(MIN_DIV)) ? cval_t'(MIN_DIV) : d;
        r.per   = c;
        r.lead  = cval_t'(1);
        r.trail = cval_t'(1) + (c >> 1);
        return r;
    endfunction

    function automatic cmp_set_t cmp_rotate(input cmp_set_t s, input int signed inc);
        cmp_set_t  r;
        int signed p;
        int signed ta;
        int signed tb;
        p  = int'({1'b0, s.per});
        ta = (int'({1'b0, s.lead})  + inc) % p;
        tb = (int'({1'b0, s.trail}) + inc) % p;
        if (ta < 0) ta = ta + p;
        if (tb < 0) tb = tb + p;
        if (ta == 0) begin
            ta = 1;
            tb = tb + 1;
        end
        r.per   = s.per;
        r.lead  = cval_t'(ta);
        r.trail = cval_t'(tb);
        return r;
    endfunction

endpackage

// File: rtl/cdiv_edge.sv
module cdiv_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic trig_o
);
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= sync_in;
    end

    assign trig_o = sync_in & ~sync_q & ~rst;
endmodule

// File: rtl/cdiv_cfg.sv
module cdiv_cfg
    import cdiv_pkg::*;
#(
    parameter int unsigned STEP_W  = 8,
    parameter int unsigned DEF_DIV = 128
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     div_we,
    input  cval_t                    div_val,
    input  logic                     step_we,
    input  logic signed [STEP_W-1:0] step_val,
    input  logic                     wrap,
    output cmp_set_t                 act_o
);
    localparam cmp_set_t RST_SET = cmp_from_div(cval_t'(DEF_DIV));

    cmp_set_t shadow_q;
    cmp_set_t active_q;
    cmp_set_t shadow_d;

    always_comb begin
        shadow_d = shadow_q;
        if (div_we)       shadow_d = cmp_from_div(div_val);
        else if (step_we) shadow_d = cmp_rotate(shadow_q, int'(step_val));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RST_SET;
            active_q <= RST_SET;
        end else begin
            shadow_q <= shadow_d;
            if (wrap) active_q <= shadow_q;
        end
    end

    assign act_o = active_q;
endmodule

// File: rtl/cdiv_wave.sv
module cdiv_wave
    import cdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     trig,
    input  cmp_set_t act,
    output cval_t    cnt_o,
    output logic     wrap_o,
    output logic     smp_o,
    output logic     hlp_o
);
    cval_t cnt_q;
    logic  smp_q;
    logic  smp_prev_q;
    logic  hlp_q;
    logic  at_per;
    logic  at_lead;
    logic  at_trail;
    logic  smp_rise;

    assign at_per   = (cnt_q == act.per);
    assign at_lead  = (cnt_q == act.lead);
    assign at_trail = (cnt_q == act.trail);
    assign smp_rise = smp_q & ~smp_prev_q;
    assign wrap_o   = at_per & ~trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            smp_q      <= 1'b0;
            smp_prev_q <= 1'b0;
            hlp_q      <= 1'b0;
        end else begin
            smp_prev_q <= smp_q;
            if (trig) begin
                cnt_q <= '0;
                smp_q <= 1'b0;
                hlp_q <= 1'b0;
            end else begin
                cnt_q <= at_per ? '0 : cnt_q + cval_t'(1);
                if (at_per)       smp_q <= 1'b0;
                else if (at_lead) smp_q <= 1'b1;
                if (smp_rise)      hlp_q <= 1'b1;
                else if (at_trail) hlp_q <= 1'b0;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign smp_o = smp_q;
    assign hlp_o = hlp_q;
endmodule

// File: rtl/carrier_phase_div.sv
module carrier_phase_div
    import cdiv_pkg::*;
#(
    parameter int unsigned STEP_W  = 8,
    parameter int unsigned DEF_DIV = 128
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     div_we,
    input  logic [15:0]              div_val,
    input  logic                     step_we,
    input  logic signed [STEP_W-1:0] step_val,
    input  logic                     frame_sync,
    output logic                     smp_clk,
    output logic                     helper_clk
);
    logic     trig;
    logic     wrap;
    cval_t    cnt;
    cmp_set_t act;

    cdiv_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sync_in(frame_sync),
        .trig_o (trig)
    );

    cdiv_cfg #(
        .STEP_W (STEP_W),
        .DEF_DIV(DEF_DIV)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .div_we  (div_we),
        .div_val (div_val),
        .step_we (step_we),
        .step_val(step_val),
        .wrap    (wrap),
        .act_o   (act)
    );

    cdiv_wave u_wave (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig),
        .act   (act),
        .cnt_o (cnt),
        .wrap_o(wrap),
        .smp_o (smp_clk),
        .hlp_o (helper_clk)
    );
endmodule

// File: rtl/carrier_phase_div_chk.sv
module carrier_phase_div_chk
    import cdiv_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     trig,
    input cval_t    cnt,
    input cmp_set_t act,
    input logic     smp,
    input logic     hlp
);
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= act.per);                                              // R1

    AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cnt == act.per && !trig) |=> !smp);                          // R3

    AST_LEAD_SET: assert property (@(posedge clk) disable iff (rst)
        (cnt == act.lead && cnt != act.per && !trig) |=> smp);        // R3

    AST_FOLLOW_SET: assert property (@(posedge clk) disable iff (rst)
        ($rose(smp) && !trig) |=> hlp);                               // R4

    AST_LEAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        act.lead >= cval_t'(1) && act.lead < act.per);                // R6

    AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cnt == '0 && !smp && !hlp));                        // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt != act.per || trig) |=> ($stable(act.per) && $stable(act.lead) && $stable(act.trail))); // R8

    AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        act.per >= cval_t'(MIN_DIV));                                 // R9
endmodule

bind carrier_phase_div carrier_phase_div_chk u_chk (
    .clk (clk),
    .rst (rst),
    .trig(trig),
    .cnt (cnt),
    .act (act),
    .smp (smp_clk),
    .hlp (helper_clk)
);

// File: tb/sim_carrier_phase_div.sv
module sim_carrier_phase_div;
    localparam int STEP_W = 8;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     div_we = 1'b0;
    logic [15:0]              div_val = '0;
    logic                     step_we = 1'b0;
    logic signed [STEP_W-1:0] step_val = '0;
    logic                     frame_sync = 1'b0;
    logic                     smp_clk;
    logic                     helper_clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    carrier_phase_div #(.STEP_W(STEP_W), .DEF_DIV(128)) u0 (
        .clk(clk), .rst(rst), .div_we(div_we), .div_val(div_val),
        .step_we(step_we), .step_val(step_val), .frame_sync(frame_sync),
        .smp_clk(smp_clk), .helper_clk(helper_clk)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int  m_cnt, m_c, m_a, m_b, s_c, s_a, s_b;
    bit  m_smp, m_hlp, m_prev, m_fsq, m_live = 0;

    always @(posedge clk) begin
        int  oc, oa, ob, ra, rb, c;
        bit  trig, wrap, old_smp;
        if (rst) begin
            m_cnt = 0; m_smp = 0; m_hlp = 0; m_prev = 0; m_fsq = 0;
            m_c = 128; m_a = 1; m_b = 65; s_c = 128; s_a = 1; s_b = 65;
            m_live = 1;
        end else begin
            trig = frame_sync && !m_fsq;
            wrap = !trig && (m_cnt == m_c);
            old_smp = m_smp;
            if (trig) begin
                m_cnt = 0; m_smp = 0; m_hlp = 0;
            end else begin
                if (m_cnt == m_c)      m_smp = 0;
                else if (m_cnt == m_a) m_smp = 1;
                if (old_smp && !m_prev) m_hlp = 1;
                else if (m_cnt == m_b)  m_hlp = 0;
                m_cnt = (m_cnt == m_c) ? 0 : m_cnt + 1;
            end
            m_prev = old_smp;
            oc = s_c; oa = s_a; ob = s_b;
            if (wrap) begin m_c = oc; m_a = oa; m_b = ob; end
            if (div_we) begin
                c = (int'(div_val) < 2) ? 2 : int'(div_val);
                s_c = c; s_a = 1; s_b = 1 + c / 2;
            end else if (step_we) begin
                ra = (oa + int'(step_val)) % oc; if (ra < 0) ra += oc;
                rb = (ob + int'(step_val)) % oc; if (rb < 0) rb += oc;
                if (ra == 0) begin ra = 1; rb = rb + 1; end
                s_a = ra; s_b = rb;
            end
            m_fsq = frame_sync;
        end
    end

    always @(negedge clk) begin
        if (m_live && !done) begin
            chk(smp_clk === m_smp, "R3 smp_clk vs model", int'(smp_clk), int'(m_smp));
            chk(helper_clk === m_hlp, "R4 helper_clk vs model", int'(helper_clk), int'(m_hlp));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_div(input int d);
        div_val = 16'(d); div_we = 1'b1;
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic step(input int s);
        step_val = STEP_W'(s); step_we = 1'b1;
        @(negedge clk);
        step_we = 1'b0;
    endtask

    // period between smp_clk rises and high time of smp_clk
    task automatic meas_smp(output int per, output int hi);
        per = 0; hi = 0;
        do @(negedge clk); while (smp_clk !== 1'b0);
        do @(negedge clk); while (smp_clk !== 1'b1);
        while (smp_clk === 1'b1) begin hi++; per++; @(negedge clk); end
        while (smp_clk === 1'b0) begin per++; @(negedge clk); end
    endtask

    task automatic meas_hlp(output int hi);
        hi = 0;
        do @(negedge clk); while (helper_clk !== 1'b0);
        do @(negedge clk); while (helper_clk !== 1'b1);
        while (helper_clk === 1'b1) begin hi++; @(negedge clk); end
    endtask

    task automatic settle_smp(output int per, output int hi);
        int p0, h0;
        meas_smp(p0, h0);
        meas_smp(per, hi);
    endtask

    initial begin
        int per, hi, hh;
        idle(3);
        chk(smp_clk === 1'b0, "R10 smp_clk in reset", int'(smp_clk), 0);
        chk(helper_clk === 1'b0, "R10 helper_clk in reset", int'(helper_clk), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(smp_clk === 1'b0 && helper_clk === 1'b0, "R10 outputs after reset", int'(smp_clk), 0);

        // default divider
        meas_smp(per, hi);
        chk(per == 129, "R1 default period", per, 129);
        chk(hi == 127, "R2 default smp high time", hi, 127);
        meas_hlp(hh);
        chk(hh == 63, "R2 default helper high time", hh, 63);

        // divider load, applied at next wrap
        load_div(10);
        settle_smp(per, hi);
        chk(per == 11, "R8 period after load", per, 11);
        chk(hi == 9, "R3 smp high after load", hi, 9);

        // forward step
        step(3);
        settle_smp(per, hi);
        chk(hi == 6, "R5 smp high after +3", hi, 6);
        meas_hlp(hh);
        chk(hh == 4, "R4 helper high after +3", hh, 4);

        // backward step wrapping below zero, then large forward step
        step(-7);
        settle_smp(per, hi);
        chk(hi == 3, "R5 smp high after -7", hi, 3);
        step(25);
        settle_smp(per, hi);
        chk(hi == 8, "R5 smp high after +25", hi, 8);

        // zero lead fix
        load_div(10);
        step(-1);
        settle_smp(per, hi);
        chk(hi == 9, "R6 lead kept off zero", hi, 9);

        // two steps before a wrap accumulate in the shadow set
        step(2);
        step(2);
        settle_smp(per, hi);
        chk(hi == 5, "R8 accumulated steps", hi, 5);

        // clamp
        load_div(1);
        settle_smp(per, hi);
        chk(per == 3, "R9 divider 1 clamps", per, 3);
        load_div(0);
        settle_smp(per, hi);
        chk(per == 3 && hi == 1, "R9 divider 0 clamps", per, 3);

        // divider load wins over simultaneous step
        div_val = 16'd20; div_we = 1'b1; step_val = STEP_W'(5); step_we = 1'b1;
        @(negedge clk);
        div_we = 1'b0; step_we = 1'b0;
        settle_smp(per, hi);
        chk(per == 21 && hi == 19, "R8 load beats step", hi, 19);

        // frame sync restart
        idle(7);
        frame_sync = 1'b1;
        @(negedge clk);
        chk(smp_clk === 1'b0 && helper_clk === 1'b0, "R7 outputs cleared", int'(smp_clk), 0);
        @(negedge clk);
        chk(smp_clk === 1'b0, "R7 smp low at count 1", int'(smp_clk), 0);
        @(negedge clk);
        chk(smp_clk === 1'b1, "R7 smp high after restart", int'(smp_clk), 1);
        idle(30);
        frame_sync = 1'b0;
        meas_smp(per, hi);
        chk(per == 21, "R1 period after restart", per, 21);
        idle(5);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule